// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns activity on one dedicated active-low interrupt pin and four general-purpose port pins into a single pending interrupt request for a processor core. Every pin first passes through a synchroniser. The dedicated pin triggers on its falling edge. The port pins trigger on their rising edges, and only when the port enable is set. Any trigger sets a request latch. The latch stays set until the core acknowledges the interrupt at the start of interrupt processing. If an edge arrives after the acknowledge, during the service routine, the latch is set again.

A sensitivity selection adds level triggering. In level mode, the latch is also kept set for as long as any enabled source holds its pin in the active state, so several open-drain sources can share one pin. The core sees a taken request only at an instruction boundary and only while its interrupt mask is clear. A request that arrives while the mask is set therefore waits until the mask is cleared on return from interrupt. Both configuration inputs are expected to stay constant after reset.

Top module: `ext_irq_latch`

## Requirements
- R1: While reset is asserted, and after it is released with all pins inactive (dedicated pin high, port pins low), `irq_pending` and `irq_req` are 0. No spurious trigger is seen on the first cycles.
- R2: With `cfg_level_mode`=0, a high-to-low transition on `irq_pin_n` sets `irq_pending` on the third rising clock edge after the pin changes. It stays set until `cpu_ack`.
- R3: `irq_req` is 1 exactly when `irq_pending`=1, `cpu_mask`=0 and `cpu_insn_done`=1.
- R4: A cycle with `cpu_ack`=1 and no trigger in that cycle clears `irq_pending` at that clock edge. A later falling edge on `irq_pin_n` sets it again.
- R5: With `cfg_level_mode`=0, a pin held in its active state after an acknowledge does not set the latch again.
- R6: With `cfg_level_mode`=1, `irq_pin_n` held low keeps `irq_pending` at 1 through any number of acknowledges.
- R7: With `cfg_port_en`=1, a low-to-high transition on any bit of `port_pins[3:0]` sets `irq_pending`, with the same three-edge latency as R2.
- R8: With `cfg_port_en`=0, `port_pins` have no effect on `irq_pending` in either sensitivity mode.
- R9: With `cfg_level_mode`=1 and `cfg_port_en`=1, `irq_pending` survives an acknowledge while any port pin is high. It clears at the first acknowledge after all port pins are low.
- R10: When an acknowledge and a new trigger fall in the same cycle, the trigger wins and `irq_pending` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_level_mode | input | 1 | 0: edge only, 1: edge plus level sensitivity |
| cfg_port_en | input | 1 | 1: port pins act as interrupt sources |
| irq_pin_n | input | 1 | Dedicated interrupt pin, active low |
| port_pins | input | 4 | Port interrupt pins, active high |
| cpu_mask | input | 1 | Core interrupt mask bit |
| cpu_insn_done | input | 1 | Strobe marking an instruction boundary |
| cpu_ack | input | 1 | Interrupt processing begins; clears the latch |
| irq_pending | output | 1 | Request latch state |
| irq_req | output | 1 | Request taken at this boundary |

## Verification
The acknowledge that clears the latch and a fresh trigger that sets it can land on the same clock edge. To provoke this, the bench first makes the latch pending through a port edge. It then drops the dedicated pin and raises `cpu_ack` exactly two edges later, so the acknowledge lines up with the edge where the synchronised transition is seen. It judges the result by `irq_pending` staying 1, and then by a second, isolated acknowledge clearing it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned PORT_W_DEF      = 4;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;
endpackage

// File: rtl/eil_rst_sync.sv
module eil_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/eil_pin_sync.sv
module eil_pin_sync #(
  parameter int unsigned     W      = 1,
  parameter int unsigned     STAGES = 2,
  parameter logic [W-1:0]    IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stg_d[s] = pin_i;
    end else begin : g_next
      always_comb stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= IDLE;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign pin_o = stg_q[STAGES-1];
endmodule

// File: rtl/eil_trigger.sv
module eil_trigger #(
  parameter int unsigned W           = 1,
  parameter bit          ACTIVE_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] level_o
);
  logic [W-1:0] act;
  logic [W-1:0] hist_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (ACTIVE_HIGH) begin : g_hi
      always_comb act[b] = sync_i[b];
    end else begin : g_lo
      always_comb act[b] = ~sync_i[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[b] <= 1'b0;
      else        hist_q[b] <= act[b];
    end

    always_comb begin
      edge_o[b]  = act[b] & ~hist_q[b];
      level_o[b] = act[b];
    end
  end
endmodule

// File: rtl/eil_req_latch.sv
module eil_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_r;

  always_comb begin
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
    else            q_d = q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q_o = q_r;
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import ext_irq_pkg::*;
#(
  parameter int unsigned PORT_W      = PORT_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_level_mode,
  input  logic              cfg_port_en,
  input  logic              irq_pin_n,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              cpu_mask,
  input  logic              cpu_insn_done,
  input  logic              cpu_ack,
  output logic              irq_pending,
  output logic              irq_req
);
  localparam logic [PORT_W-1:0] PORT_IDLE = '0;

  sense_e      sense;
  logic        rst_sync_n;
  logic        ded_sync;
  logic        ded_edge;
  logic        ded_lvl;
  logic [PORT_W-1:0] port_sync;
  logic [PORT_W-1:0] port_edge;
  logic [PORT_W-1:0] port_lvl;
  logic        ded_hit;
  logic        port_hit;
  logic        set_any;

  assign sense = sense_e'(cfg_level_mode);

  eil_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  eil_pin_sync #(.W(1), .STAGES(SYNC_STAGES), .IDLE(1'b1)) u_ded_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(irq_pin_n), .pin_o(ded_sync)
  );

  eil_pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .IDLE(PORT_IDLE)) u_port_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(port_pins), .pin_o(port_sync)
  );

  eil_trigger #(.W(1), .ACTIVE_HIGH(1'b0)) u_ded_trig (
    .clk(clk), .rst_n(rst_sync_n), .sync_i(ded_sync),
    .edge_o(ded_edge), .level_o(ded_lvl)
  );

  eil_trigger #(.W(PORT_W), .ACTIVE_HIGH(1'b1)) u_port_trig (
    .clk(clk), .rst_n(rst_sync_n), .sync_i(port_sync),
    .edge_o(port_edge), .level_o(port_lvl)
  );

  always_comb begin
    ded_hit  = ded_edge | ((sense == SENSE_LEVEL) & ded_lvl);
    port_hit = cfg_port_en &
               ((|port_edge) | ((sense == SENSE_LEVEL) & (|port_lvl)));
    set_any  = ded_hit | port_hit;
  end

  eil_req_latch u_latch (
    .clk(clk), .rst_n(rst_sync_n), .set_i(set_any), .clr_i(cpu_ack),
    .q_o(irq_pending)
  );

  assign irq_req = irq_pending & ~cpu_mask & cpu_insn_done;
endmodule

// File: rtl/eil_checker.sv
module eil_checker (
  input logic clk,
  input logic rst_sync_n,
  input logic cfg_level_mode,
  input logic ded_lvl,
  input logic set_any,
  input logic cpu_ack,
  input logic irq_pending
);
  // R2: the latch only rises after a trigger seen by the set logic
  a_r2_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_pending) |-> $past(set_any));

  // R2: without an acknowledge the latch holds
  a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_pending && !cpu_ack) |=> irq_pending);

  // R4: an acknowledge with no trigger clears the latch
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_ack && !set_any) |=> !irq_pending);

  // R10: a trigger beats a simultaneous acknowledge
  a_r10_trigger_beats_ack: assert property (@(posedge clk) disable iff (!rst_sync_n)
    set_any |=> irq_pending);

  // R6: level mode with the dedicated pin active keeps the latch set
  a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_level_mode && ded_lvl) |=> irq_pending);
endmodule

bind ext_irq_latch eil_checker u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cfg_level_mode(cfg_level_mode),
  .ded_lvl(ded_lvl), .set_any(set_any), .cpu_ack(cpu_ack),
  .irq_pending(irq_pending)
);

// File: tb/ext_irq_latch_tb_top.sv
`timescale 1ns/1ps
module ext_irq_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_level_mode;
  logic       cfg_port_en;
  logic       irq_pin_n;
  logic [3:0] port_pins;
  logic       cpu_mask;
  logic       cpu_insn_done;
  logic       cpu_ack;
  logic       irq_pending;
  logic       irq_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  ext_irq_latch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_level_mode(cfg_level_mode),
    .cfg_port_en(cfg_port_en), .irq_pin_n(irq_pin_n), .port_pins(port_pins),
    .cpu_mask(cpu_mask), .cpu_insn_done(cpu_insn_done), .cpu_ack(cpu_ack),
    .irq_pending(irq_pending), .irq_req(irq_req)
  );

  // [13] irq_pin_n, [12:9] port, [8] ack, [7] mask, [6] insn_done,
  // [5:2] cycles, [1] expected pending, [0] expected req
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0},
    {1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0},
    {1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 1'b1},
    {1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 4'd1, 1'b1, 1'b0},
    {1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0},
    {1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0},
    {1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0},
    {1'b1, 4'h0, 1'b1, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0},
    {1'b1, 4'h4, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0},
    {1'b1, 4'h4, 1'b1, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0},
    {1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0}
  };
  string vtag [NV] = '{"R1", "R2", "R3", "R3", "R5", "R4", "R4", "R4",
                       "R7", "R5", "R7"};

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic lvl, input logic pen);
    rst_n = 1'b0;
    cfg_level_mode = lvl; cfg_port_en = pen;
    irq_pin_n = 1'b1; port_pins = 4'h0;
    cpu_mask = 1'b0; cpu_insn_done = 1'b0; cpu_ack = 1'b0;
    step(3);
    chk("R1 pending in reset", irq_pending, 1'b0);
    rst_n = 1'b1;
    step(4);
    chk("R1 pending after reset", irq_pending, 1'b0);
    chk("R1 req after reset", irq_req, 1'b0);
  endtask

  task automatic ack_pulse();
    cpu_ack = 1'b1;
    step(1);
    cpu_ack = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0, 1'b1);

    for (int v = 0; v < NV; v++) begin
      irq_pin_n     = VEC[v][13];
      port_pins     = VEC[v][12:9];
      cpu_ack       = VEC[v][8];
      cpu_mask      = VEC[v][7];
      cpu_insn_done = VEC[v][6];
      step(1);
      cpu_ack = 1'b0;
      if (VEC[v][5:2] > 1) step(int'(VEC[v][5:2]) - 1);
      chk({vtag[v], " pending"}, irq_pending, VEC[v][1]);
      chk({vtag[v], " req"}, irq_req, VEC[v][0]);
      cpu_insn_done = 1'b0;
    end

    // R10: acknowledge on the very edge where a new trigger is seen
    port_pins = 4'h1;
    step(3);
    chk("R7 port bit0 pending", irq_pending, 1'b1);
    irq_pin_n = 1'b0;
    step(2);
    ack_pulse();
    chk("R10 trigger beats ack", irq_pending, 1'b1);
    ack_pulse();
    chk("R4 isolated ack clears", irq_pending, 1'b0);

    // R8: port pins ignored when disabled, edge then level mode
    do_reset(1'b0, 1'b0);
    port_pins = 4'hF;
    step(4);
    chk("R8 port disabled edge mode", irq_pending, 1'b0);
    do_reset(1'b1, 1'b0);
    port_pins = 4'hF;
    step(4);
    chk("R8 port disabled level mode", irq_pending, 1'b0);

    // R6 and R9: level mode
    do_reset(1'b1, 1'b1);
    irq_pin_n = 1'b0;
    step(3);
    chk("R6 level set", irq_pending, 1'b1);
    ack_pulse();
    chk("R6 survives ack", irq_pending, 1'b1);
    ack_pulse();
    chk("R6 survives second ack", irq_pending, 1'b1);
    irq_pin_n = 1'b1;
    step(4);
    ack_pulse();
    chk("R6 clears after release", irq_pending, 1'b0);

    port_pins = 4'h3;
    step(3);
    chk("R9 port level set", irq_pending, 1'b1);
    ack_pulse();
    chk("R9 survives ack", irq_pending, 1'b1);
    port_pins = 4'h2;
    step(4);
    ack_pulse();
    chk("R9 one source still high", irq_pending, 1'b1);
    port_pins = 4'h0;
    step(4);
    ack_pulse();
    chk("R9 clears when all low", irq_pending, 1'b0);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule